// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block models the device-side control of a two-bank synchronous DRAM. On every rising clock edge it samples clock enable, chip select, the three strobes (row, column, write) and a 12-bit address, turns them into a single command, and applies that command to a small state model. The model holds one idle/active flag and one open row per bank, a mode register with a validity flag, and a burst counter that closes a bank by itself when an auto-precharge access finishes.

Address bit 11 picks the bank for activate, precharge, write and read. Address bit 10 turns a precharge into a precharge of both banks, and turns a write or read into its auto-precharge form. Commands that break the model's sequencing rules raise a one-cycle error flag and change no state. Every output is registered, so each command shows up at the ports right after the edge that sampled it.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: A cycle with cke low or cs_n high is a deselect. cmd_code reads 1, and no bank flag, open row, mode register or burst counter changes.
- R2: With cke high and cs_n low, {ras_n,cas_n,we_n} decode as follows: 000 mode set (code 2), 001 refresh (3), 010 precharge (4, or 5 when addr[10]=1), 011 activate (6), 100 write (7, or 8 when addr[10]=1), 101 read (9, or 10 when addr[10]=1), 110 burst stop (11), 111 no-op (0).
- R3: An activate to an idle bank sets that bank's bit in bank_active (bank = addr[11]) and stores addr[10:0] in open_rows[b*11 +: 11].
- R4: An activate to a bank that is already active sets err and leaves the stored row unchanged.
- R5: A precharge with addr[10]=0 closes only the bank addr[11] selects. With addr[10]=1 it closes both banks. A precharge also cancels a burst running in a bank it closes.
- R6: A write or read to an idle bank, or issued while mode_valid is 0, sets err and starts no burst.
- R7: A mode set with both banks idle loads addr into mode_reg and sets mode_valid. A mode set or refresh while any bank is active sets err and leaves mode_reg unchanged.
- R8: Burst length comes from mode_reg[2:0]: 0→1, 1→2, 2→4, 3→8, 7→full page, and other values→1. After an accepted access of length L, burst_busy is high for the L samples that follow the access edge, counting only non-deselect cycles.
- R9: An auto-precharge access of length L at edge k makes its bank idle after edge k+L, counting only non-deselect cycles. A plain access leaves the bank open.
- R10: A full-page burst keeps burst_busy high until a burst stop, and an auto-precharge request on it is ignored. A burst stop when no full-page burst is running changes nothing.
- R11: A write or read issued while an auto-precharge burst is still running sets err and is ignored.
- R12: A synchronous active-low reset clears bank_active, mode_reg, mode_valid, burst_busy and err, and sets cmd_code to 0.
- R13: Each non-deselect command loads cmd_bank with addr[11], cmd_row with addr[10:0] and cmd_col with addr[7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock enable; low means the cycle is held |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | 12 | Address: bank in bit 11, auto/all flag in bit 10 |
| cmd_code | output | 4 | Code of the last sampled command |
| cmd_bank | output | 1 | Bank bit of the last non-deselect command |
| cmd_row | output | 11 | Row field of the last non-deselect command |
| cmd_col | output | 8 | Column field of the last non-deselect command |
| bank_active | output | 2 | Active flag per bank |
| open_rows | output | 22 | Open row per bank, 11 bits each, bank 1 in the upper field |
| mode_reg | output | 12 | Mode register contents |
| mode_valid | output | 1 | High once a mode set has been accepted |
| burst_busy | output | 1 | A read or write burst is running |
| err | output | 1 | One-cycle pulse for an illegal command |

## Verification
A wrong bank flag shows up on bank_active right after the edge, and it changes whether err fires on the next activate or access to that bank. A burst counter that is off by one makes burst_busy fall one sample early or late, and makes an auto-precharged bank go idle at the wrong edge. The bench therefore samples both in every cycle of a burst. A mode register that was loaded wrongly only shows up once the next access picks a burst length, so every mode set is followed by a burst whose exact length is checked.

// File: rtl/sdcmd_pkg.sv
// Shared command codes and the burst-length lookup for the SDRAM command tracker.
// Assumes the mode register keeps its burst-length code in its three lowest bits.
package sdcmd_pkg;

    typedef enum logic [3:0] {
        CMD_NOP  = 4'd0,
        CMD_DESL = 4'd1,
        CMD_MRS  = 4'd2,
        CMD_REF  = 4'd3,
        CMD_PRE  = 4'd4,
        CMD_PALL = 4'd5,
        CMD_ACT  = 4'd6,
        CMD_WR   = 4'd7,
        CMD_WRA  = 4'd8,
        CMD_RD   = 4'd9,
        CMD_RDA  = 4'd10,
        CMD_BST  = 4'd11
    } cmd_e;

    localparam logic [2:0] BL_FULL_CODE = 3'd7;

    // Turns a burst-length code into a beat count; reserved codes count as one beat.
    function automatic int beats_of(input logic [2:0] code);
        case (code)
            3'd0:    return 1;
            3'd1:    return 2;
            3'd2:    return 4;
            3'd3:    return 8;
            default: return 1;
        endcase
    endfunction

endpackage

// File: rtl/sdcmd_decode.sv
// Command decoder: maps the sampled control pins onto one command code.
// Assumes the pins are sampled at the same edge that uses the result; it has no state.
module sdcmd_decode
    import sdcmd_pkg::*;
(
    input  logic cke,
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic ap_bit,
    output cmd_e cmd
);

    // Picks the command from the strobe pattern; a held cycle gives a deselect.
    always_comb begin
        if (!cke || cs_n) begin
            cmd = CMD_DESL;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b000:  cmd = CMD_MRS;
                3'b001:  cmd = CMD_REF;
                3'b010:  cmd = ap_bit ? CMD_PALL : CMD_PRE;
                3'b011:  cmd = CMD_ACT;
                3'b100:  cmd = ap_bit ? CMD_WRA : CMD_WR;
                3'b101:  cmd = ap_bit ? CMD_RDA : CMD_RD;
                3'b110:  cmd = CMD_BST;
                default: cmd = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/sdcmd_bank.sv
// One bank's state: an active flag and the row latched by the last activate.
// Assumes the caller never asks to open and close in the same cycle and never opens an active bank.
module sdcmd_bank #(
    parameter int ROW_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_req,
    input  logic             close_req,
    input  logic [ROW_W-1:0] row_in,
    output logic             active,
    output logic [ROW_W-1:0] row
);

    // Opens the bank and latches the row, or closes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            row    <= '0;
        end else if (open_req) begin
            active <= 1'b1;
            row    <= row_in;
        end else if (close_req) begin
            active <= 1'b0;
        end
    end

    AST_NO_OPEN_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        !(open_req && close_req)); // R3

    AST_ROW_HELD_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(active)) |-> $stable(row)); // R4

endmodule

// File: rtl/sdcmd_burst.sv
// Burst counter: tracks the running read/write burst and requests auto-precharge when it ends.
// Assumes the caller blocks a new start while an auto-precharge burst runs, and holds it on deselect.
module sdcmd_burst #(
    parameter int BEAT_MAX = 8,
    parameter int BEAT_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              start,
    input  logic [BEAT_W-1:0] start_beats,
    input  logic              start_full,
    input  logic              start_ap,
    input  logic              start_bank,
    input  logic              stop,
    input  logic              kill,
    output logic              busy,
    output logic              ap_pending,
    output logic              ap_close,
    output logic              burst_bank
);

    logic [BEAT_W-1:0] cnt;
    logic              full_q;
    logic              ap_q;

    // Loads, ends or counts down the burst; frozen while the cycle is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt        <= '0;
            full_q     <= 1'b0;
            ap_q       <= 1'b0;
            burst_bank <= 1'b0;
        end else if (!hold) begin
            if (start) begin
                cnt        <= start_full ? '0 : start_beats;
                full_q     <= start_full;
                ap_q       <= start_ap && !start_full;
                burst_bank <= start_bank;
            end else if (kill || (stop && full_q)) begin
                cnt    <= '0;
                full_q <= 1'b0;
                ap_q   <= 1'b0;
            end else if (cnt != '0) begin
                cnt <= cnt - BEAT_W'(1);
                if (cnt == BEAT_W'(1)) begin
                    ap_q <= 1'b0;
                end
            end
        end
    end

    // Reports the burst state and the closing pulse of the last beat.
    always_comb begin
        busy       = full_q || (cnt != '0);
        ap_pending = ap_q;
        ap_close   = !hold && ap_q && !full_q && (cnt == BEAT_W'(1));
    end

    AST_BEATS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= BEAT_W'(BEAT_MAX)); // R8

    AST_AP_HAS_BEATS: assert property (@(posedge clk) disable iff (!rst_n)
        ap_q |-> (cnt != '0)); // R9

    AST_HELD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(hold)) |-> ($stable(cnt) && $stable(full_q))); // R1

endmodule

// File: rtl/sdram_cmd_tracker.sv
// SDRAM command decoder with a two-bank tracker, the mode register and auto-precharge.
// Assumes the pins are synchronous to clk; illegal commands only pulse err and change no state.
module sdram_cmd_tracker
    import sdcmd_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int ROW_W    = 11,
    parameter int COL_W    = 8,
    parameter int AP_BIT   = 10,
    parameter int BEAT_MAX = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cke,
    input  logic                  cs_n,
    input  logic                  ras_n,
    input  logic                  cas_n,
    input  logic                  we_n,
    input  logic [ADDR_W-1:0]     addr,
    output logic [3:0]            cmd_code,
    output logic                  cmd_bank,
    output logic [ROW_W-1:0]      cmd_row,
    output logic [COL_W-1:0]      cmd_col,
    output logic [1:0]            bank_active,
    output logic [2*ROW_W-1:0]    open_rows,
    output logic [ADDR_W-1:0]     mode_reg,
    output logic                  mode_valid,
    output logic                  burst_busy,
    output logic                  err
);

    localparam int NBANK    = 2;
    localparam int BANK_BIT = ADDR_W - 1;
    localparam int BEAT_W   = $clog2(BEAT_MAX + 1);

    cmd_e              cur_cmd;
    cmd_e              cmd_q;
    logic              held;
    logic              sel_bank;
    logic              sel_open;
    logic              any_open;
    logic              is_access;
    logic              acc_ok;
    logic              act_ok;
    logic              mrs_ok;
    logic              bad;
    logic              kill;
    logic              stop;
    logic [BEAT_W-1:0] start_beats;
    logic              start_full;
    logic              start_ap;
    logic [NBANK-1:0]  open_req;
    logic [NBANK-1:0]  close_req;
    logic [NBANK-1:0]  bank_active_w;
    logic [2*ROW_W-1:0] open_rows_w;
    logic [ADDR_W-1:0] mode_q;
    logic              mode_ok_q;
    logic              busy_w;
    logic              ap_pending;
    logic              ap_close;
    logic              burst_bank;
    logic              err_q;
    logic              bank_q;
    logic [ROW_W-1:0]  row_q;
    logic [COL_W-1:0]  col_q;

    sdcmd_decode u_decode (
        .cke    (cke),
        .cs_n   (cs_n),
        .ras_n  (ras_n),
        .cas_n  (cas_n),
        .we_n   (we_n),
        .ap_bit (addr[AP_BIT]),
        .cmd    (cur_cmd)
    );

    // Checks the decoded command against bank and mode state.
    always_comb begin
        held      = (cur_cmd == CMD_DESL);
        sel_bank  = addr[BANK_BIT];
        sel_open  = bank_active_w[sel_bank];
        any_open  = |bank_active_w;
        is_access = (cur_cmd == CMD_WR) || (cur_cmd == CMD_WRA) ||
                    (cur_cmd == CMD_RD) || (cur_cmd == CMD_RDA);
        start_ap  = (cur_cmd == CMD_WRA) || (cur_cmd == CMD_RDA);
        acc_ok    = is_access && sel_open && mode_ok_q && !ap_pending;
        act_ok    = (cur_cmd == CMD_ACT) && !sel_open;
        mrs_ok    = (cur_cmd == CMD_MRS) && !any_open;
        bad       = (is_access && !acc_ok) ||
                    ((cur_cmd == CMD_ACT) && sel_open) ||
                    (((cur_cmd == CMD_MRS) || (cur_cmd == CMD_REF)) && any_open);
        kill      = (cur_cmd == CMD_PALL) ||
                    ((cur_cmd == CMD_PRE) && (sel_bank == burst_bank));
        stop      = (cur_cmd == CMD_BST);
    end

    // Derives the length of a new burst from the mode register.
    always_comb begin
        start_full  = (mode_q[2:0] == BL_FULL_CODE);
        start_beats = BEAT_W'(beats_of(mode_q[2:0]));
    end

    // Builds the open and close requests for each bank.
    always_comb begin
        for (int b = 0; b < NBANK; b++) begin
            open_req[b]  = act_ok && (sel_bank == 1'(b));
            close_req[b] = (cur_cmd == CMD_PALL) ||
                           ((cur_cmd == CMD_PRE) && (sel_bank == 1'(b))) ||
                           (ap_close && (burst_bank == 1'(b)));
        end
    end

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        sdcmd_bank #(
            .ROW_W (ROW_W)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .open_req  (open_req[g]),
            .close_req (close_req[g]),
            .row_in    (addr[ROW_W-1:0]),
            .active    (bank_active_w[g]),
            .row       (open_rows_w[g*ROW_W +: ROW_W])
        );
    end

    sdcmd_burst #(
        .BEAT_MAX (BEAT_MAX),
        .BEAT_W   (BEAT_W)
    ) u_burst (
        .clk         (clk),
        .rst_n       (rst_n),
        .hold        (held),
        .start       (acc_ok),
        .start_beats (start_beats),
        .start_full  (start_full),
        .start_ap    (start_ap),
        .start_bank  (sel_bank),
        .stop        (stop),
        .kill        (kill),
        .busy        (busy_w),
        .ap_pending  (ap_pending),
        .ap_close    (ap_close),
        .burst_bank  (burst_bank)
    );

    // Registers the command, its address fields, the error pulse and the mode register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q     <= CMD_NOP;
            bank_q    <= 1'b0;
            row_q     <= '0;
            col_q     <= '0;
            err_q     <= 1'b0;
            mode_q    <= '0;
            mode_ok_q <= 1'b0;
        end else begin
            cmd_q <= cur_cmd;
            err_q <= bad;
            if (!held) begin
                bank_q <= sel_bank;
                row_q  <= addr[ROW_W-1:0];
                col_q  <= addr[COL_W-1:0];
            end
            if (mrs_ok) begin
                mode_q    <= addr;
                mode_ok_q <= 1'b1;
            end
        end
    end

    // Drives the ports from the registered state.
    always_comb begin
        cmd_code    = cmd_q;
        cmd_bank    = bank_q;
        cmd_row     = row_q;
        cmd_col     = col_q;
        bank_active = bank_active_w;
        open_rows   = open_rows_w;
        mode_reg    = mode_q;
        mode_valid  = mode_ok_q;
        burst_busy  = busy_w;
        err         = err_q;
    end

    AST_DESL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(held)) |-> ($stable(bank_active_w) && $stable(mode_q))); // R1

    AST_MODE_SET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_ok_q) |-> ($past(bank_active_w) == '0)); // R7

    AST_BAD_ACT_KEEPS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && err_q && (cmd_q == CMD_ACT)) |-> $stable(open_rows_w)); // R4

    AST_AP_SHUTS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ap_close)) |-> !bank_active_w[$past(burst_bank)]); // R9

endmodule

// File: tb/sdram_cmd_tracker_tb.sv
module sdram_cmd_tracker_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCH_CYC  = 20000;
    localparam int NVEC       = 18;

    localparam logic [3:0] P_MRS  = 4'b0000;
    localparam logic [3:0] P_REF  = 4'b0001;
    localparam logic [3:0] P_PRE  = 4'b0010;
    localparam logic [3:0] P_ACT  = 4'b0011;
    localparam logic [3:0] P_WR   = 4'b0100;
    localparam logic [3:0] P_RD   = 4'b0101;
    localparam logic [3:0] P_BST  = 4'b0110;
    localparam logic [3:0] P_NOP  = 4'b0111;
    localparam logic [3:0] P_DESL = 4'b1111;

    // {pins[4], cke, addr[12], exp cmd[4], exp active[2], exp busy, exp err}
    localparam logic [24:0] VEC [NVEC] = '{
        {P_NOP,  1'b1, 12'h000, 4'd0,  2'b00, 1'b0, 1'b0},
        {P_MRS,  1'b1, 12'h001, 4'd2,  2'b00, 1'b0, 1'b0},
        {P_ACT,  1'b1, 12'h155, 4'd6,  2'b01, 1'b0, 1'b0},
        {P_ACT,  1'b1, 12'hAAA, 4'd6,  2'b11, 1'b0, 1'b0},
        {P_ACT,  1'b1, 12'h000, 4'd6,  2'b11, 1'b0, 1'b1},
        {P_RD,   1'b1, 12'h805, 4'd9,  2'b11, 1'b1, 1'b0},
        {P_NOP,  1'b1, 12'h000, 4'd0,  2'b11, 1'b1, 1'b0},
        {P_NOP,  1'b1, 12'h000, 4'd0,  2'b11, 1'b0, 1'b0},
        {P_WR,   1'b1, 12'h410, 4'd8,  2'b11, 1'b1, 1'b0},
        {P_NOP,  1'b1, 12'h000, 4'd0,  2'b11, 1'b1, 1'b0},
        {P_NOP,  1'b1, 12'h000, 4'd0,  2'b10, 1'b0, 1'b0},
        {P_WR,   1'b1, 12'h010, 4'd7,  2'b10, 1'b0, 1'b1},
        {P_MRS,  1'b1, 12'h000, 4'd2,  2'b10, 1'b0, 1'b1},
        {P_PRE,  1'b1, 12'h800, 4'd4,  2'b00, 1'b0, 1'b0},
        {P_REF,  1'b1, 12'h000, 4'd3,  2'b00, 1'b0, 1'b0},
        {P_DESL, 1'b1, 12'h000, 4'd1,  2'b00, 1'b0, 1'b0},
        {P_ACT,  1'b0, 12'h000, 4'd1,  2'b00, 1'b0, 1'b0},
        {P_BST,  1'b1, 12'h000, 4'd11, 2'b00, 1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b1;
    logic        cs_n = 1'b0;
    logic        ras_n = 1'b1;
    logic        cas_n = 1'b1;
    logic        we_n = 1'b1;
    logic [11:0] addr = '0;
    logic [3:0]  cmd_code;
    logic        cmd_bank;
    logic [10:0] cmd_row;
    logic [7:0]  cmd_col;
    logic [1:0]  bank_active;
    logic [21:0] open_rows;
    logic [11:0] mode_reg;
    logic        mode_valid;
    logic        burst_busy;
    logic        err;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_cmd_tracker dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cke         (cke),
        .cs_n        (cs_n),
        .ras_n       (ras_n),
        .cas_n       (cas_n),
        .we_n        (we_n),
        .addr        (addr),
        .cmd_code    (cmd_code),
        .cmd_bank    (cmd_bank),
        .cmd_row     (cmd_row),
        .cmd_col     (cmd_col),
        .bank_active (bank_active),
        .open_rows   (open_rows),
        .mode_reg    (mode_reg),
        .mode_valid  (mode_valid),
        .burst_busy  (burst_busy),
        .err         (err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drives one command at a falling edge and waits past the next rising edge.
    task automatic cyc(input logic [3:0] pins, input logic k, input logic [11:0] a);
        {cs_n, ras_n, cas_n, we_n} = pins;
        cke  = k;
        addr = a;
        @(negedge clk);
    endtask

    initial begin
        repeat (WATCH_CYC) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        {cs_n, ras_n, cas_n, we_n} = P_NOP;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R12 reset state
        chk("R12 cmd_code", cmd_code, 0);
        chk("R12 bank_active", bank_active, 0);
        chk("R12 mode_valid", mode_valid, 0);
        chk("R12 burst_busy", burst_busy, 0);
        chk("R12 err", err, 0);

        // Table walk: R2 codes, R3 activate, R4, R5, R6, R7, R8, R9, R1, R10
        for (int i = 0; i < NVEC; i++) begin
            cyc(VEC[i][24:21], VEC[i][20], VEC[i][19:8]);
            chk($sformatf("R2 vec%0d cmd_code", i), cmd_code, VEC[i][7:4]);
            chk($sformatf("R5 R9 vec%0d bank_active", i), bank_active, VEC[i][3:2]);
            chk($sformatf("R8 vec%0d burst_busy", i), burst_busy, VEC[i][1]);
            chk($sformatf("R6 R7 vec%0d err", i), err, VEC[i][0]);
        end
        chk("R7 mode kept after refused set", mode_reg, 12'h001);

        // R3 and R13: row storage and field capture
        cyc(P_ACT, 1'b1, 12'hBC5);
        chk("R3 bank1 row", open_rows[21:11], 11'h3C5);
        chk("R13 cmd_bank", cmd_bank, 1);
        chk("R13 cmd_row", cmd_row, 11'h3C5);
        cyc(P_ACT, 1'b1, 12'h0F0);
        chk("R3 bank0 row", open_rows[10:0], 11'h0F0);
        cyc(P_ACT, 1'b1, 12'h111);
        chk("R4 err on reopen", err, 1);
        chk("R4 row kept", open_rows[10:0], 11'h0F0);
        cyc(P_RD, 1'b1, 12'h03A);
        chk("R13 cmd_col", cmd_col, 8'h3A);
        chk("R13 cmd_bank zero", cmd_bank, 0);
        cyc(P_DESL, 1'b1, 12'hFFF);
        chk("R1 fields held", cmd_col, 8'h3A);
        chk("R1 busy held", burst_busy, 1);
        cyc(P_NOP, 1'b1, 12'h000);
        cyc(P_NOP, 1'b1, 12'h000);
        chk("R8 two beats done", burst_busy, 0);
        chk("R9 plain read keeps bank", bank_active, 2'b11);

        // R5 precharge of both banks
        cyc(P_PRE, 1'b1, 12'h400);
        chk("R5 all cmd_code", cmd_code, 5);
        chk("R5 all closed", bank_active, 0);

        // R10 full page
        cyc(P_MRS, 1'b1, 12'h007);
        chk("R7 mode_reg", mode_reg, 12'h007);
        chk("R7 mode_valid", mode_valid, 1);
        cyc(P_ACT, 1'b1, 12'h000);
        cyc(P_RD, 1'b1, 12'h400);
        chk("R10 full start cmd", cmd_code, 10);
        for (int n = 0; n < 20; n++) cyc(P_NOP, 1'b1, 12'h000);
        chk("R10 full busy", burst_busy, 1);
        chk("R10 auto ignored", bank_active, 2'b01);
        cyc(P_BST, 1'b1, 12'h000);
        chk("R10 stop ends", burst_busy, 0);
        chk("R10 bank still open", bank_active, 2'b01);

        // R11 and R9 with a length-four auto-precharge write
        cyc(P_PRE, 1'b1, 12'h000);
        chk("R5 single close", bank_active, 0);
        cyc(P_MRS, 1'b1, 12'h002);
        cyc(P_ACT, 1'b1, 12'h805);
        cyc(P_WR, 1'b1, 12'hC00);
        chk("R9 write auto cmd", cmd_code, 8);
        cyc(P_RD, 1'b1, 12'h800);
        chk("R11 err", err, 1);
        chk("R11 busy kept", burst_busy, 1);
        for (int n = 0; n < 3; n++) cyc(P_DESL, 1'b1, 12'h000);
        chk("R1 desl code", cmd_code, 1);
        chk("R1 burst frozen", burst_busy, 1);
        chk("R1 bank frozen", bank_active, 2'b10);
        cyc(P_NOP, 1'b1, 12'h000);
        cyc(P_NOP, 1'b1, 12'h000);
        chk("R9 last beat open", bank_active, 2'b10);
        cyc(P_NOP, 1'b1, 12'h000);
        chk("R9 auto closed", bank_active, 0);
        chk("R8 four beats done", burst_busy, 0);

        // R12 reset mid-run, then R6 access before mode set
        rst_n = 1'b0;
        cyc(P_NOP, 1'b1, 12'h000);
        cyc(P_NOP, 1'b1, 12'h000);
        rst_n = 1'b1;
        chk("R12 mode_valid cleared", mode_valid, 0);
        chk("R12 mode_reg cleared", mode_reg, 0);
        cyc(P_ACT, 1'b1, 12'h000);
        chk("R3 open after reset", bank_active, 2'b01);
        cyc(P_RD, 1'b1, 12'h000);
        chk("R6 err without mode", err, 1);
        chk("R6 no burst", burst_busy, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule